// File: doc/BRIEF.md
# Two-Wire Controller Status Word

This block keeps the status word of a two-wire (I2C/SMBus-style) controller that can act as bus host or as bus client. The bit-level bus engine feeds it single-cycle event pulses (start, repeated start, stop, address match or mismatch, NACK, lost arbitration, byte moves between holding registers and shifters, SMBus conditions). It also receives FIFO level signals, live SDA/SCL samples and the access strobes of the register interface. It merges these into one 32-bit read-only word.

Each flag follows its own rule. Some are sticky and clear when the word is read. Some clear when the transmit holding register is written or the receive holding register is read. Some set and clear on bus events. Others are plain live levels. The meaning of the transfer flags depends on three settings: host or client mode, FIFO or single holding register, and clock stretching on or off. When a flag is set and cleared in the same cycle, setting wins, so no event is lost.

Top module: `twi_status_word`

## Requirements
- R1: One cycle after synchronous reset, with `fifo_en`=0, `sda_in`=`scl_in`=1 and `clk_wait`=`tx_fifo_lock`=0, the word reads 32'h0300_0005 (SDA bit 25, SCL bit 24, TXRDY bit 2, TXCOMP bit 0). Bits 3, 11-15, 22 and 27-31 always read 0.
- R2: These flags set on their event and hold until the word is read: repeated start (bit 26, `ev_rep_start`), SMBus flags (bits 16-21, driven by `smb_ev[0]`..`smb_ev[5]` in that order), NACK (bit 8, `ev_nack`) and general call (bit 5, `ev_gen_call`, client mode only).
- R3: While `sr_rd` is high the word still shows the flags before clearing. The read clears the R2, R4 and R12 flags on the next cycle. An event in the same cycle as the read leaves its flag set.
- R4: In host mode (`host_mode`=1), `ev_arb_lost` sets arbitration-lost (bit 9) and TXCOMP (bit 0) together. In client mode it changes neither.
- R5: In host mode, `ev_nack` sets NACK (bit 8), TXCOMP (bit 0) and TXRDY (bit 2) together.
- R6: Client access (bit 4) sets on `ev_addr_match` in client mode and clears on `ev_nack` or `ev_stop`. A status read does not clear it.
- R7: In client mode, TXCOMP clears on `ev_start` and sets on `ev_stop` or `ev_addr_mismatch`.
- R8: In host mode, TXCOMP sets on `ev_host_done` and clears on `thr_wr`. If both fall in the same cycle, it stays set.
- R9: With `fifo_en`=0, TXRDY sets on `ev_tx_load`, `ev_nack` or `host_enable` and clears on `thr_wr`.
- R10: With `fifo_en`=0, RXRDY (bit 1) sets on `ev_rx_load` and clears on `rhr_rd`.
- R11: With `fifo_en`=1, TXRDY equals `!tx_fifo_full` and RXRDY equals `!rx_fifo_empty` in the same cycle.
- R12: Overrun (bit 6) sets when `ev_rx_load` arrives while RXRDY is 1. Underrun (bit 7) sets on `ev_underrun`. Both are reported only in client mode with `stretch_en`=0.
- R13: SDA (bit 25) and SCL (bit 24) show the line inputs one cycle later. Clock-wait (bit 10) and TX FIFO lock (bit 23) show their inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_mode | input | 1 | 1 = host, 0 = client |
| fifo_en | input | 1 | FIFO mode selects live ready levels |
| stretch_en | input | 1 | Client clock stretching enabled |
| sda_in | input | 1 | Data line sample |
| scl_in | input | 1 | Clock line sample |
| clk_wait | input | 1 | Clock currently held low by this client |
| tx_fifo_lock | input | 1 | Transmit FIFO locked |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| ev_start | input | 1 | Start seen |
| ev_rep_start | input | 1 | Repeated start seen |
| ev_stop | input | 1 | Stop seen or sent |
| ev_addr_match | input | 1 | Address equals own client address |
| ev_addr_mismatch | input | 1 | Address after repeated start is not own |
| ev_gen_call | input | 1 | General call seen |
| ev_nack | input | 1 | Byte not acknowledged |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_host_done | input | 1 | Holding register and shifter empty, stop sent |
| ev_tx_load | input | 1 | Byte moved from transmit holding register to shifter |
| ev_rx_load | input | 1 | Byte placed in receive holding register |
| ev_underrun | input | 1 | Transmit data not supplied in time |
| host_enable | input | 1 | Host function enabled |
| smb_ev | input | 6 | SMBus events: host code, alert, timeout, PEC error, default address, host header |
| sr_rd | input | 1 | Status word read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| status_word | output | 32 | Status word |

## Verification
The main collision is between a clearing access and a setting event in the same cycle. For a sticky flag, the collision is a status read meeting its event. For TXCOMP in host mode, it is a transmit holding register write meeting `ev_host_done`. The bench raises both strobes in one cycle, then samples the word after the edge and expects the flag still set. A read on its own in the next cycle must then clear the sticky flag. The bench also checks that the word seen during a read still holds the value before clearing.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;

    localparam int WORD_W    = 32;
    localparam int SMB_W     = 6;

    // Bit positions of the status word
    localparam int B_TXCOMP  = 0;
    localparam int B_RXRDY   = 1;
    localparam int B_TXRDY   = 2;
    localparam int B_SVACC   = 4;
    localparam int B_GACC    = 5;
    localparam int B_OVRE    = 6;
    localparam int B_UNRE    = 7;
    localparam int B_NACK    = 8;
    localparam int B_ARBLST  = 9;
    localparam int B_CLKWAIT = 10;
    localparam int B_SMB_LO  = 16;
    localparam int B_TXLOCK  = 23;
    localparam int B_SCL     = 24;
    localparam int B_SDA     = 25;
    localparam int B_RSTART  = 26;

    localparam logic [WORD_W-1:0] UNUSED_MASK = 32'hF840_F808;
    localparam logic [WORD_W-1:0] RESET_WORD  = 32'h0300_0005;

    // Sticky, clear-on-read flags
    typedef struct packed {
        logic             rstart;
        logic [SMB_W-1:0] smb;
        logic             arblst;
        logic             nack;
        logic             unre;
        logic             ovre;
        logic             gacc;
    } sticky_t;

    localparam int N_STICKY = $bits(sticky_t);

    // Transfer flags driven by bus events and holding-register access
    typedef struct packed {
        logic svacc;
        logic txcomp;
        logic txrdy;
        logic rxrdy;
    } xfer_t;

    typedef struct packed {
        logic sda;
        logic scl;
        logic clk_wait;
        logic tx_lock;
        logic txrdy;
        logic rxrdy;
    } live_t;

    function automatic logic [WORD_W-1:0] pack_word(input sticky_t s,
                                                    input xfer_t   x,
                                                    input live_t   l);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_TXCOMP]                      = x.txcomp;
        w[B_RXRDY]                       = l.rxrdy;
        w[B_TXRDY]                       = l.txrdy;
        w[B_SVACC]                       = x.svacc;
        w[B_GACC]                        = s.gacc;
        w[B_OVRE]                        = s.ovre;
        w[B_UNRE]                        = s.unre;
        w[B_NACK]                        = s.nack;
        w[B_ARBLST]                      = s.arblst;
        w[B_CLKWAIT]                     = l.clk_wait;
        w[B_SMB_LO +: SMB_W]             = s.smb;
        w[B_TXLOCK]                      = l.tx_lock;
        w[B_SCL]                         = l.scl;
        w[B_SDA]                         = l.sda;
        w[B_RSTART]                      = s.rstart;
        return w;
    endfunction

endpackage

// File: rtl/twi_sticky_bank.sv
module twi_sticky_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         rd_clr_i,
    output logic [N-1:0] q_o
);
    // Each flag: set has priority over the read clear
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (set_i[i])
                q <= 1'b1;
            else if (rd_clr_i)
                q <= 1'b0;
        end
        assign q_o[i] = q;
    end
endmodule

// File: rtl/twi_line_sample.sv
module twi_line_sample #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_i,
    input  logic scl_i,
    output logic sda_o,
    output logic scl_o
);
    localparam int W = 2;

    logic [W-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] d;
        if (s == 0) begin : g_first
            assign d = {sda_i, scl_i};
        end else begin : g_next
            assign d = stage[s-1];
        end
        // Idle bus lines are high, so reset to 1
        always_ff @(posedge clk) begin
            if (rst)
                stage[s] <= '1;
            else
                stage[s] <= d;
        end
    end

    assign sda_o = stage[STAGES-1][1];
    assign scl_o = stage[STAGES-1][0];
endmodule

// File: rtl/twi_xfer_flags.sv
module twi_xfer_flags
    import twi_stat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  host_mode,
    input  logic  ev_start,
    input  logic  ev_stop,
    input  logic  ev_nack,
    input  logic  ev_arb_lost,
    input  logic  ev_addr_match,
    input  logic  ev_addr_mismatch,
    input  logic  ev_host_done,
    input  logic  ev_tx_load,
    input  logic  ev_rx_load,
    input  logic  host_enable,
    input  logic  thr_wr,
    input  logic  rhr_rd,
    output xfer_t q_o
);
    xfer_t q, d;

    always_comb begin
        d = q;

        // Client access: match wins over nack/stop, read has no effect
        if (ev_addr_match && !host_mode)
            d.svacc = 1'b1;
        else if (ev_nack || ev_stop)
            d.svacc = 1'b0;

        // Transfer complete: rules differ by mode, set wins over clear
        if (host_mode) begin
            if (ev_host_done || ev_arb_lost || ev_nack)
                d.txcomp = 1'b1;
            else if (thr_wr)
                d.txcomp = 1'b0;
        end else begin
            if (ev_stop || ev_addr_mismatch)
                d.txcomp = 1'b1;
            else if (ev_start)
                d.txcomp = 1'b0;
        end

        // Holding-register ready flags
        if (ev_tx_load || ev_nack || host_enable)
            d.txrdy = 1'b1;
        else if (thr_wr)
            d.txrdy = 1'b0;

        if (ev_rx_load)
            d.rxrdy = 1'b1;
        else if (rhr_rd)
            d.rxrdy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '{svacc: 1'b0, txcomp: 1'b1, txrdy: 1'b1, rxrdy: 1'b0};
        else
            q <= d;
    end

    assign q_o = q;
endmodule

// File: rtl/twi_status_word.sv
module twi_status_word
    import twi_stat_pkg::*;
#(
    parameter int LINE_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic              fifo_en,
    input  logic              stretch_en,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              clk_wait,
    input  logic              tx_fifo_lock,
    input  logic              tx_fifo_full,
    input  logic              rx_fifo_empty,
    input  logic              ev_start,
    input  logic              ev_rep_start,
    input  logic              ev_stop,
    input  logic              ev_addr_match,
    input  logic              ev_addr_mismatch,
    input  logic              ev_gen_call,
    input  logic              ev_nack,
    input  logic              ev_arb_lost,
    input  logic              ev_host_done,
    input  logic              ev_tx_load,
    input  logic              ev_rx_load,
    input  logic              ev_underrun,
    input  logic              host_enable,
    input  logic [SMB_W-1:0]  smb_ev,
    input  logic              sr_rd,
    input  logic              thr_wr,
    input  logic              rhr_rd,
    output logic [WORD_W-1:0] status_word
);
    xfer_t   xf;
    sticky_t st_set, st_q;
    live_t   lv;
    logic    sda_s, scl_s;
    logic    client_nostretch;

    twi_xfer_flags u_xfer (
        .clk              (clk),
        .rst              (rst),
        .host_mode        (host_mode),
        .ev_start         (ev_start),
        .ev_stop          (ev_stop),
        .ev_nack          (ev_nack),
        .ev_arb_lost      (ev_arb_lost),
        .ev_addr_match    (ev_addr_match),
        .ev_addr_mismatch (ev_addr_mismatch),
        .ev_host_done     (ev_host_done),
        .ev_tx_load       (ev_tx_load),
        .ev_rx_load       (ev_rx_load),
        .host_enable      (host_enable),
        .thr_wr           (thr_wr),
        .rhr_rd           (rhr_rd),
        .q_o              (xf)
    );

    twi_line_sample #(.STAGES(LINE_STAGES)) u_lines (
        .clk   (clk),
        .rst   (rst),
        .sda_i (sda_in),
        .scl_i (scl_in),
        .sda_o (sda_s),
        .scl_o (scl_s)
    );

    // Ready levels: live FIFO state or the holding-register flags
    always_comb begin
        lv.sda      = sda_s;
        lv.scl      = scl_s;
        lv.clk_wait = clk_wait;
        lv.tx_lock  = tx_fifo_lock;
        lv.txrdy    = fifo_en ? !tx_fifo_full  : xf.txrdy;
        lv.rxrdy    = fifo_en ? !rx_fifo_empty : xf.rxrdy;
    end

    assign client_nostretch = !host_mode && !stretch_en;

    always_comb begin
        st_set.rstart = ev_rep_start;
        st_set.smb    = smb_ev;
        st_set.arblst = ev_arb_lost && host_mode;
        st_set.nack   = ev_nack;
        st_set.unre   = ev_underrun && client_nostretch;
        st_set.ovre   = ev_rx_load && lv.rxrdy && client_nostretch;
        st_set.gacc   = ev_gen_call && !host_mode;
    end

    twi_sticky_bank #(.N(N_STICKY)) u_sticky (
        .clk      (clk),
        .rst      (rst),
        .set_i    (st_set),
        .rd_clr_i (sr_rd),
        .q_o      (st_q)
    );

    assign status_word = pack_word(st_q, xf, lv);
endmodule

// File: rtl/twi_status_word_chk.sv
module twi_status_word_chk (
    input logic        clk,
    input logic        rst,
    input logic        host_mode,
    input logic        sr_rd,
    input logic        ev_nack,
    input logic        ev_stop,
    input logic        ev_start,
    input logic        ev_arb_lost,
    input logic        ev_addr_mismatch,
    input logic [31:0] status_word
);
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (status_word & 32'hF840_F808) == 32'h0);

    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (status_word[8] && !sr_rd) |=> status_word[8]);

    p_read_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (sr_rd && !ev_nack) |=> !status_word[8]);

    p_event_wins_r3: assert property (@(posedge clk) disable iff (rst)
        ev_nack |=> status_word[8]);

    p_arb_txcomp_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_arb_lost && host_mode) |=> (status_word[9] && status_word[0]));

    p_svacc_read_r6: assert property (@(posedge clk) disable iff (rst)
        (status_word[4] && sr_rd && !ev_nack && !ev_stop) |=> status_word[4]);

    p_client_start_r7: assert property (@(posedge clk) disable iff (rst)
        (!host_mode && ev_start && !ev_stop && !ev_addr_mismatch) |=> !status_word[0]);
endmodule

bind twi_status_word twi_status_word_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .host_mode        (host_mode),
    .sr_rd            (sr_rd),
    .ev_nack          (ev_nack),
    .ev_stop          (ev_stop),
    .ev_start         (ev_start),
    .ev_arb_lost      (ev_arb_lost),
    .ev_addr_mismatch (ev_addr_mismatch),
    .status_word      (status_word)
);

// File: tb/twi_status_word_bench.sv
`timescale 1ns/1ps
module twi_status_word_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_mode = 1'b0, fifo_en = 1'b0, stretch_en = 1'b0;
    logic sda_in = 1'b1, scl_in = 1'b1, clk_wait = 1'b0, tx_fifo_lock = 1'b0;
    logic tx_fifo_full = 1'b0, rx_fifo_empty = 1'b1;
    logic ev_start = 0, ev_rep_start = 0, ev_stop = 0, ev_addr_match = 0;
    logic ev_addr_mismatch = 0, ev_gen_call = 0, ev_nack = 0, ev_arb_lost = 0;
    logic ev_host_done = 0, ev_tx_load = 0, ev_rx_load = 0, ev_underrun = 0;
    logic host_enable = 0;
    logic [5:0] smb_ev = '0;
    logic sr_rd = 0, thr_wr = 0, rhr_rd = 0;
    logic [31:0] status_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    twi_status_word u_twi_status_word (.*);

    // {host_mode, event code, expected bit}
    localparam logic [9:0] VEC [10] = '{
        {1'b0, 4'd0, 5'd26},
        {1'b0, 4'd1, 5'd16},
        {1'b0, 4'd2, 5'd17},
        {1'b0, 4'd3, 5'd18},
        {1'b0, 4'd4, 5'd19},
        {1'b0, 4'd5, 5'd20},
        {1'b0, 4'd6, 5'd21},
        {1'b1, 4'd7, 5'd9},
        {1'b0, 4'd8, 5'd8},
        {1'b0, 4'd9, 5'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ev_start = 0; ev_rep_start = 0; ev_stop = 0; ev_addr_match = 0;
        ev_addr_mismatch = 0; ev_gen_call = 0; ev_nack = 0; ev_arb_lost = 0;
        ev_host_done = 0; ev_tx_load = 0; ev_rx_load = 0; ev_underrun = 0;
        host_enable = 0; smb_ev = '0; sr_rd = 0; thr_wr = 0; rhr_rd = 0;
    endtask

    task automatic fire(input int code);
        case (code)
            0: ev_rep_start = 1;
            1, 2, 3, 4, 5, 6: smb_ev[code-1] = 1;
            7: ev_arb_lost = 1;
            8: ev_nack = 1;
            default: ev_gen_call = 1;
        endcase
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        check("R1 reset word", status_word, 32'h0300_0005);

        // Table walk: sticky flags set, read shows old value, then clear
        for (int i = 0; i < 10; i++) begin
            host_mode = VEC[i][9];
            fire(int'(VEC[i][8:5]));
            tick();
            check("R2 sticky set", 32'(status_word[VEC[i][4:0]]), 32'd1);
            check("R1 unused zero", status_word & 32'hF840_F808, 32'd0);
            sr_rd = 1;
            #1 check("R3 pre-clear value", 32'(status_word[VEC[i][4:0]]), 32'd1);
            tick();
            check("R3 cleared after read", 32'(status_word[VEC[i][4:0]]), 32'd0);
        end

        // R3: read and event in the same cycle
        host_mode = 0;
        ev_nack = 1; tick();
        sr_rd = 1; ev_nack = 1; tick();
        check("R3 event beats read", 32'(status_word[8]), 32'd1);
        sr_rd = 1; tick();
        check("R3 read clears", 32'(status_word[8]), 32'd0);

        // R4: arbitration lost ignored in client mode
        host_mode = 0; ev_arb_lost = 1; tick();
        check("R4 client arb ignored", 32'(status_word[9]), 32'd0);

        // R5, R8, R9: host nack after holding write
        host_mode = 1; thr_wr = 1; tick();
        check("R8 thr write clears txcomp", 32'(status_word[0]), 32'd0);
        check("R9 thr write clears txrdy", 32'(status_word[2]), 32'd0);
        ev_nack = 1; tick();
        check("R5 nack txcomp txrdy", 32'(status_word[8:0] & 9'h105), 32'h105);
        sr_rd = 1; tick();

        // R4: host arbitration lost sets txcomp too
        thr_wr = 1; tick();
        ev_arb_lost = 1; tick();
        check("R4 arb and txcomp", 32'({status_word[9], status_word[0]}), 32'd3);
        sr_rd = 1; tick();

        // R8: host done vs thr write
        thr_wr = 1; tick();
        ev_host_done = 1; tick();
        check("R8 host done sets", 32'(status_word[0]), 32'd1);
        thr_wr = 1; tick();
        ev_host_done = 1; thr_wr = 1; tick();
        check("R8 done beats write", 32'(status_word[0]), 32'd1);

        // R9: txrdy sources
        thr_wr = 1; tick();
        ev_tx_load = 1; tick();
        check("R9 tx load sets", 32'(status_word[2]), 32'd1);
        thr_wr = 1; tick();
        host_enable = 1; tick();
        check("R9 host enable sets", 32'(status_word[2]), 32'd1);

        // R6: client access
        host_mode = 0; ev_addr_match = 1; tick();
        check("R6 match sets", 32'(status_word[4]), 32'd1);
        sr_rd = 1; tick();
        check("R6 read keeps", 32'(status_word[4]), 32'd1);
        ev_stop = 1; tick();
        check("R6 stop clears", 32'(status_word[4]), 32'd0);

        // R7: client txcomp
        ev_start = 1; tick();
        check("R7 start clears", 32'(status_word[0]), 32'd0);
        ev_addr_mismatch = 1; tick();
        check("R7 mismatch sets", 32'(status_word[0]), 32'd1);
        ev_start = 1; tick();
        ev_stop = 1; tick();
        check("R7 stop sets", 32'(status_word[0]), 32'd1);

        // R10: rx ready
        ev_rx_load = 1; tick();
        check("R10 rx load sets", 32'(status_word[1]), 32'd1);
        rhr_rd = 1; tick();
        check("R10 rhr read clears", 32'(status_word[1]), 32'd0);

        // R12: overrun / underrun gating
        stretch_en = 0;
        ev_rx_load = 1; tick();
        check("R12 first load no overrun", 32'(status_word[6]), 32'd0);
        ev_rx_load = 1; tick();
        check("R12 overrun", 32'(status_word[6]), 32'd1);
        sr_rd = 1; rhr_rd = 1; tick();
        stretch_en = 1;
        ev_rx_load = 1; tick();
        ev_rx_load = 1; tick();
        check("R12 overrun masked by stretching", 32'(status_word[6]), 32'd0);
        rhr_rd = 1; tick();
        stretch_en = 0; ev_underrun = 1; tick();
        check("R12 underrun", 32'(status_word[7]), 32'd1);
        sr_rd = 1; tick();
        host_mode = 1; ev_underrun = 1; tick();
        check("R12 underrun masked in host", 32'(status_word[7]), 32'd0);

        // R13: live lines
        sda_in = 0; scl_in = 0; #1;
        check("R13 lines sampled late", 32'(status_word[25:24]), 32'd3);
        tick();
        check("R13 lines after edge", 32'(status_word[25:24]), 32'd0);
        clk_wait = 1; tx_fifo_lock = 1; #1;
        check("R13 wait and lock", 32'({status_word[23], status_word[10]}), 32'd3);

        // R11: FIFO mode ready levels
        fifo_en = 1; tx_fifo_full = 1; rx_fifo_empty = 0; #1;
        check("R11 fifo full", 32'(status_word[2]), 32'd0);
        check("R11 fifo not empty", 32'(status_word[1]), 32'd1);
        tx_fifo_full = 0; rx_fifo_empty = 1; #1;
        check("R11 fifo levels", 32'(status_word[2:1]), 32'd2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule